// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit plaintext block under a 128-bit key. It reuses one combinational cipher round for ten clock cycles. A 128-bit state register feeds each round's result back into the next round. Beside the data round, one key-expansion step runs in every cycle and derives that round's key from the previous one. Round keys are therefore never stored as a table.

A block enters on a valid/ready input stream that carries the plaintext and the key together. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. The producer must hold its data until that edge. `in_ready` drops while a block is in rounds one to nine and rises again in the final round cycle. A new block can therefore follow every ten cycles.

The result leaves on a plain valid strobe. `out_valid` is high for exactly one cycle, and `out_text` carries the ciphertext only in that cycle. The output has no ready signal and cannot be stalled, so the consumer must capture the ciphertext when `out_valid` is high.

Top module: `aes128_iter_enc`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0. A reset that arrives during a block abandons that block, and no result is produced for it.
- R2: During cycles one to nine after an accepted block, `in_ready` is 0.
- R3: The ciphertext equals AES-128 encryption of the plaintext under the key. The bytes are big-endian: byte 0 is bits 127:120, and column c holds bytes 4c to 4c+3. Example: key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: `out_valid` is high for exactly one cycle. That cycle is the tenth cycle after the accepting edge.
- R5: Data offered while `in_ready` is 0 is ignored. The running block's result is unchanged, and no extra result appears.
- R6: `in_ready` is 1 during the final round cycle. A block offered in that cycle is accepted, so results come out back to back ten cycles apart, and each one is correct.
- R7: The round constant is 0x01 in round one and doubles in GF(2^8) each round, reducing by 0x1B on overflow. It is 0x36 in round ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Plaintext and key are offered |
| in_ready | output | 1 | A block can be accepted this cycle |
| in_text | input | 128 | Plaintext block |
| in_key | input | 128 | Cipher key |
| out_valid | output | 1 | One-cycle strobe: ciphertext present |
| out_text | output | 128 | Ciphertext, meaningful only while out_valid is 1 |

## Verification
The assertions check the handshake and sequencing rules on every cycle:
- `in_ready` stays low in the middle rounds.
- An accepted transfer loads the whitened state and starts round one.
- An offer made while busy only advances the round count.
- `out_valid` never lasts two cycles.
- The round constant is 0x36 in the last round.

Only the bench scenarios can show that the ciphertext is right. They cover the published vector, an all-zero vector and random blocks. They also show that data offered while busy leaves the result unchanged, that back-to-back blocks chained in the final cycle each come out correct, and that a reset during a block produces no result.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int BLK_W     = 128;
  localparam int BYTE_W    = 8;
  localparam int NBYTES    = BLK_W / BYTE_W;
  localparam int NCOLS     = 4;
  localparam int WORD_W    = BYTE_W * NCOLS;
  localparam int NROUNDS   = 10;
  localparam logic [7:0] RCON_FIRST = 8'h01;
  localparam logic [7:0] RCON_LAST  = 8'h36;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_dbl(x);
    end
    return acc;
  endfunction

  // substitution: inverse as a^254 (0 maps to 0), then the affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] inv;
    p   = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p   = gf_mul(p, p);
      inv = gf_mul(inv, p);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_enc_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);
  assign y = sbox_calc(a);
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             final_i,
  output logic [BLK_W-1:0] state_o
);
  logic [BYTE_W-1:0] sb [NBYTES];
  logic [BYTE_W-1:0] sh [NBYTES];
  logic [BYTE_W-1:0] mx [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_sub
    aes_sbox u_sbox (.a(state_i[BLK_W-1-BYTE_W*g -: BYTE_W]), .y(sb[g]));
  end

  // row r of column c takes the byte from column (c+r) mod 4
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < NCOLS; r++) begin : g_row
      assign sh[NCOLS*c+r] = sb[NCOLS*((c+r)%NCOLS)+r];
    end
    assign mx[NCOLS*c+0] = gf_dbl(sh[NCOLS*c+0]) ^ gf_dbl(sh[NCOLS*c+1]) ^ sh[NCOLS*c+1]
                         ^ sh[NCOLS*c+2] ^ sh[NCOLS*c+3];
    assign mx[NCOLS*c+1] = sh[NCOLS*c+0] ^ gf_dbl(sh[NCOLS*c+1]) ^ gf_dbl(sh[NCOLS*c+2])
                         ^ sh[NCOLS*c+2] ^ sh[NCOLS*c+3];
    assign mx[NCOLS*c+2] = sh[NCOLS*c+0] ^ sh[NCOLS*c+1] ^ gf_dbl(sh[NCOLS*c+2])
                         ^ gf_dbl(sh[NCOLS*c+3]) ^ sh[NCOLS*c+3];
    assign mx[NCOLS*c+3] = gf_dbl(sh[NCOLS*c+0]) ^ sh[NCOLS*c+0] ^ sh[NCOLS*c+1]
                         ^ sh[NCOLS*c+2] ^ gf_dbl(sh[NCOLS*c+3]);
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_add
    assign state_o[BLK_W-1-BYTE_W*g -: BYTE_W] =
      (final_i ? sh[g] : mx[g]) ^ rkey_i[BLK_W-1-BYTE_W*g -: BYTE_W];
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0]  key_i,
  input  logic [BYTE_W-1:0] rcon_i,
  output logic [BLK_W-1:0]  key_o
);
  logic [WORD_W-1:0] w   [NCOLS];
  logic [WORD_W-1:0] nw  [NCOLS];
  logic [WORD_W-1:0] rot;
  logic [WORD_W-1:0] subw;
  logic [WORD_W-1:0] mixw;

  for (genvar k = 0; k < NCOLS; k++) begin : g_split
    assign w[k] = key_i[BLK_W-1-WORD_W*k -: WORD_W];
  end

  assign rot = {w[NCOLS-1][WORD_W-BYTE_W-1:0], w[NCOLS-1][WORD_W-1 -: BYTE_W]};

  for (genvar g = 0; g < NCOLS; g++) begin : g_sub
    aes_sbox u_sbox (.a(rot[WORD_W-1-BYTE_W*g -: BYTE_W]), .y(subw[WORD_W-1-BYTE_W*g -: BYTE_W]));
  end

  assign mixw = subw ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

  for (genvar k = 0; k < NCOLS; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign nw[k] = w[k] ^ mixw;
    end else begin : g_rest
      assign nw[k] = w[k] ^ nw[k-1];
    end
    assign key_o[BLK_W-1-WORD_W*k -: WORD_W] = nw[k];
  end
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_text,
  input  logic [BLK_W-1:0] in_key,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_text
);
  localparam int CNT_W = $clog2(NROUNDS + 1);

  logic [CNT_W-1:0]  rnd_q;
  logic [BLK_W-1:0]  state_q;
  logic [BLK_W-1:0]  key_q;
  logic [BYTE_W-1:0] rcon_q;
  logic [BLK_W-1:0]  key_nx;
  logic [BLK_W-1:0]  state_nx;
  logic              busy;
  logic              last;
  logic              accept;

  assign busy     = (rnd_q != '0);
  assign last     = (rnd_q == CNT_W'(NROUNDS));
  assign in_ready = !busy || last;
  assign accept   = in_valid && in_ready;

  aes_key_step u_key (.key_i(key_q), .rcon_i(rcon_q), .key_o(key_nx));
  aes_round    u_round (.state_i(state_q), .rkey_i(key_nx), .final_i(last), .state_o(state_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_q   <= '0;
      state_q <= '0;
      key_q   <= '0;
      rcon_q  <= '0;
    end else if (accept) begin
      rnd_q   <= CNT_W'(1);
      state_q <= in_text ^ in_key;
      key_q   <= in_key;
      rcon_q  <= RCON_FIRST;
    end else if (last) begin
      rnd_q   <= '0;
    end else if (busy) begin
      rnd_q   <= rnd_q + 1'b1;
      state_q <= state_nx;
      key_q   <= key_nx;
      rcon_q  <= gf_dbl(rcon_q);
    end
  end

  assign out_valid = last;
  assign out_text  = state_nx;

  a_r2_ready_low_mid: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |-> !in_ready);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r5_busy_offer_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (rnd_q == CNT_W'($past(rnd_q) + 1'b1)));
  a_r6_accept_loads: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (rnd_q == CNT_W'(1) && state_q == $past(in_text ^ in_key)));
  a_r7_rcon_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (rcon_q == RCON_FIRST));
  a_r7_rcon_last: assert property (@(posedge clk) disable iff (rst)
    last |-> (rcon_q == RCON_LAST));
endmodule

// File: tb/aes128_iter_enc_tb.sv
`timescale 1ns/1ps
module aes128_iter_enc_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_text = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_text;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  int         log_t  [256];
  logic [7:0] alog_t [256];
  logic [7:0] sb_t   [256];

  always #5 clk = ~clk;

  aes128_iter_enc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_text(in_text), .in_key(in_key), .out_valid(out_valid), .out_text(out_text)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return alog_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    logic [7:0]  st [16];
    logic [7:0]  tmp [16];
    logic [7:0]  sh [16];
    logic [7:0]  a0, a1, a2, a3;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb_t[t[31:24]] ^ rc, sb_t[t[23:16]], sb_t[t[15:8]], sb_t[t[7:0]]};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int i = 0; i < 16; i++) st[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) tmp[i] = sb_t[st[i]];
      for (int c = 0; c < 4; c++)
        for (int row = 0; row < 4; row++)
          sh[4*c+row] = tmp[4*((c+row)%4)+row];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = sh[4*c]; a1 = sh[4*c+1]; a2 = sh[4*c+2]; a3 = sh[4*c+3];
          sh[4*c]   = gm(a0, 2) ^ gm(a1, 3) ^ a2 ^ a3;
          sh[4*c+1] = a0 ^ gm(a1, 2) ^ gm(a2, 3) ^ a3;
          sh[4*c+2] = a0 ^ a1 ^ gm(a2, 2) ^ gm(a3, 3);
          sh[4*c+3] = gm(a0, 3) ^ a1 ^ a2 ^ gm(a3, 2);
        end
      end
      for (int i = 0; i < 16; i++) st[i] = sh[i] ^ w[4*r + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
    return res;
  endfunction

  // Offer a block at the current negedge (in_ready assumed high) and follow it
  // through ten cycles; junk drives data while busy (R5), tag names the ciphertext check.
  task automatic run_block(input logic [127:0] pt, input logic [127:0] key,
                           input bit junk, input string tag);
    logic [127:0] expv;
    expv = ref_enc(pt, key);
    in_valid = 1'b1; in_text = pt; in_key = key;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k < 10) begin
        chk(in_ready == 1'b0, "R2 ready low mid-block", {127'd0, in_ready}, 128'd0);
        chk(out_valid == 1'b0, "R4 no early result", {127'd0, out_valid}, 128'd0);
        if (junk) begin
          in_valid = 1'b1;
          in_text = {$urandom, $urandom, $urandom, $urandom};
          in_key  = {$urandom, $urandom, $urandom, $urandom};
        end else begin
          in_valid = 1'b0;
        end
      end else begin
        chk(out_valid == 1'b1, "R4 result in tenth cycle", {127'd0, out_valid}, 128'd1);
        chk(in_ready == 1'b1, "R6 ready in final cycle", {127'd0, in_ready}, 128'd1);
        chk(out_text == expv, tag, out_text, expv);
        if (junk) chk(out_text == expv, "R5 busy offers ignored", out_text, expv);
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 pulse lasts one cycle", {127'd0, out_valid}, 128'd0);
    chk(in_ready == 1'b1, "R1 idle ready", {127'd0, in_ready}, 128'd1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 128'd0, 128'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] x;
    logic [7:0] inv;
    logic [7:0] s;
    void'($urandom(32'd20240611));
    // tables: powers of generator 3, logarithms, substitution via inverse + affine
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      alog_t[i] = x;
      log_t[x] = i;
      x = x ^ {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    alog_t[255] = 8'h01;
    log_t[0] = 0;
    for (int b = 0; b < 256; b++) begin
      inv = (b == 0) ? 8'h00 : alog_t[(255 - log_t[b]) % 255];
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb_t[b] = s;
    end

    // R3: reference model against the published vector
    chk(ref_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f)
        == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 reference model",
        ref_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1 reset ready", {127'd0, in_ready}, 128'd1);
    chk(out_valid == 1'b0, "R1 reset no result", {127'd0, out_valid}, 128'd0);

    run_block(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
              1'b0, "R3 published vector");
    chk(out_text == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 published value",
        out_text, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    idle_check();
    run_block(128'd0, 128'd0, 1'b0, "R3 all-zero vector");
    idle_check();
    run_block({128{1'b1}}, {128{1'b1}}, 1'b1, "R3 R7 all-ones with busy offers");
    idle_check();

    // R1: reset in the middle of a block abandons it
    in_valid = 1'b1; in_text = 128'h1234; in_key = 128'h5678;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1 reset mid-block ready", {127'd0, in_ready}, 128'd1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 abandoned block gives no result", {127'd0, out_valid}, 128'd0);
    end

    // R6: back-to-back pair, directed
    run_block(128'hffeeddccbbaa99887766554433221100, 128'h0f0e0d0c0b0a09080706050403020100,
              1'b0, "R6 first of chain");
    run_block(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
              1'b1, "R6 chained block");
    idle_check();

    // random mix of isolated, chained and busy-offer blocks
    for (int n = 0; n < 30; n++) begin
      bit junk;
      bit chain;
      junk  = 1'($urandom % 2);
      chain = 1'($urandom % 2);
      run_block({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                junk, chain ? "R6 R7 random chained" : "R3 R7 random");
      if (!chain) begin
        idle_check();
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    idle_check();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule